// File: doc/BRIEF.md
# Interrupt context save sequencer

When an interrupt is accepted, this block stores the machine context on a byte-addressed stack. The context is the 16-bit flag word and the 20-bit program counter. A single start pulse picks one of two stack pointers and captures the context. The block then issues a short train of memory writes, each one held until the memory acknowledges it. When the last write completes, it reports the new stack pointer together with a one-cycle done pulse.

The width of the writes follows the parity of the chosen stack pointer. An even pointer lets the context go out as two 16-bit words. An odd pointer would make word writes misaligned, so the same four bytes go out one at a time. In both cases the result in memory is identical, and the pointer drops by four.

Pointer choice depends on the interrupt source. A software interrupt numbered 32 through 63 uses the stack named by the user-stack select flag. Every other interrupt uses the interrupt stack.

Top module: `ctx_save_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the write strobe and the done pulse are both low, even if start is held high during reset.
- R2: If the interrupt is software-raised with a number from 32 to 63 and the user-stack select is high, the user stack pointer is used and `sp_user_o` reads 1 with done. In every other case the interrupt stack pointer is used and `sp_user_o` reads 0.
- R3: For an even selected pointer S, exactly two word writes (`wr_word_o`=1) are issued. The first goes to S-2 and the second to S-4.
- R4: For an odd selected pointer S, exactly four byte writes (`wr_word_o`=0) are issued, at S-1, S-2, S-3 and S-4 in that order. The byte sits in `wr_data_o[7:0]` and bits 15:8 are zero.
- R5: The four bytes below S end up holding the following values:
  - S-4 holds PC[7:0].
  - S-3 holds PC[15:8].
  - S-2 holds FLG[7:0].
  - S-1 holds {FLG[15:12], PC[19:16]}.
- R6: A word write always targets an even address, with the even-address byte in `wr_data_o[7:0]` and the following odd-address byte in `wr_data_o[15:8]`.
- R7: Each write keeps its strobe, address, data and size steady until a cycle in which `wr_ack_i` is high. The next write, or done, follows on the cycle after.
- R8: A start pulse that arrives while a save is in progress has no effect. Neither the writes nor the reported pointer change, and no extra writes follow.
- R9: One cycle after the last acknowledged write, `done_o` is high for exactly one cycle, with `sp_o` equal to S-4 modulo 2^AW. No write strobe follows unless a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Interrupt accepted, one-cycle pulse |
| isp_i | input | AW | Interrupt stack pointer |
| usp_i | input | AW | User stack pointer |
| ustk_sel_i | input | 1 | User-stack select flag |
| swint_i | input | 1 | Interrupt was raised by software |
| swnum_i | input | SWN_W | Software interrupt number |
| flg_i | input | FLGW | Flag word to save |
| pc_i | input | PCW | Program counter to save |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 16 | Write data (byte in bits 7:0 for byte writes) |
| wr_word_o | output | 1 | 1 = 16-bit write, 0 = 8-bit write |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Save complete, one-cycle pulse |
| sp_o | output | AW | Updated stack pointer, valid with done |
| sp_user_o | output | 1 | 1 if the user pointer is the one to update |

## Verification
The step counter and the captured pointer drive every write. A corrupted step shows up as a wrong address, a wrong size or a wrong byte lane on the very next strobe. It can also show up as one write too many or too few before done. A captured pointer that changes mid-save, for example by wrongly accepting a second start, shows on the next write address and on `sp_o` at done. Each of these appears within one acknowledged write of the fault, so the bench compares every strobe, not just the final pointer.

// File: rtl/ctxsave_pkg.sv
package ctxsave_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_FIN   = 2'd2
   } seq_state_e;

   localparam int CTX_BYTES = 4;
   localparam int BUS_W     = 16;
endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
   parameter int AW     = 16,
   parameter int SWN_W  = 6,
   parameter int USR_LO = 32,
   parameter int USR_HI = 63
) (
   input  logic [AW-1:0]    isp_i,
   input  logic [AW-1:0]    usp_i,
   input  logic             ustk_sel_i,
   input  logic             swint_i,
   input  logic [SWN_W-1:0] swnum_i,
   output logic [AW-1:0]    sp_o,
   output logic             is_user_o
);
   localparam int NW = SWN_W + 1;
   localparam logic [NW-1:0] LO_V = NW'(USR_LO);
   localparam logic [NW-1:0] HI_V = NW'(USR_HI);

   generate
      if (USR_LO > USR_HI || USR_HI >= (1 << SWN_W)) begin : g_bad_range
         $error("ctx_sp_select: user-stack number range does not fit SWN_W");
      end
   endgenerate

   logic [NW-1:0] num_ext;
   logic          in_range;

   assign num_ext   = {1'b0, swnum_i};
   assign in_range  = swint_i && (num_ext >= LO_V) && (num_ext <= HI_V);
   assign is_user_o = in_range && ustk_sel_i;
   assign sp_o      = is_user_o ? usp_i : isp_i;
endmodule

// File: rtl/ctx_write_plan.sv
module ctx_write_plan #(
   parameter int AW    = 16,
   parameter int CTX_B = 4,
   parameter int DW    = 16
) (
   input  logic [1:0]         step_i,
   input  logic               odd_i,
   input  logic [AW-1:0]      base_i,
   input  logic [8*CTX_B-1:0] img_i,
   output logic [AW-1:0]      addr_o,
   output logic [DW-1:0]      data_o,
   output logic               word_o,
   output logic               last_o
);
   generate
      if (CTX_B != 4) begin : g_bad_ctx
         $error("ctx_write_plan: context image must be four bytes");
      end
      if (DW != 16) begin : g_bad_bus
         $error("ctx_write_plan: write bus must be 16 bits");
      end
   endgenerate

   logic [7:0] lane [CTX_B];

   generate
      for (genvar g = 0; g < CTX_B; g++) begin : g_lane
         assign lane[g] = img_i[8*g +: 8];
      end
   endgenerate

   // byte offset above base-4 for the current step
   logic [1:0] off;

   always_comb begin
      if (odd_i) off = 2'd3 - step_i;
      else       off = {~step_i[0], 1'b0};
   end

   assign addr_o = base_i - AW'(CTX_B) + AW'(off);
   assign data_o = odd_i ? {8'h00, lane[off]} : {lane[off | 2'd1], lane[off]};
   assign word_o = !odd_i;
   assign last_o = odd_i ? (step_i == 2'd3) : step_i[0];
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
   import ctxsave_pkg::*;
#(
   parameter int AW     = 16,
   parameter int FLGW   = 16,
   parameter int PCW    = 20,
   parameter int SWN_W  = 6,
   parameter int USR_LO = 32,
   parameter int USR_HI = 63
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [AW-1:0]    isp_i,
   input  logic [AW-1:0]    usp_i,
   input  logic             ustk_sel_i,
   input  logic             swint_i,
   input  logic [SWN_W-1:0] swnum_i,
   input  logic [FLGW-1:0]  flg_i,
   input  logic [PCW-1:0]   pc_i,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [15:0]      wr_data_o,
   output logic             wr_word_o,
   input  logic             wr_ack_i,
   output logic             done_o,
   output logic [AW-1:0]    sp_o,
   output logic             sp_user_o
);
   localparam int IMG_W = 8 * CTX_BYTES;

   generate
      if (FLGW != 16 || PCW != 20) begin : g_bad_ctx
         $error("ctx_save_seq: context layout needs a 16-bit flag word and a 20-bit PC");
      end
      if (AW < 4) begin : g_bad_aw
         $error("ctx_save_seq: stack pointer too narrow");
      end
   endgenerate

   seq_state_e       state;
   logic [1:0]       step;
   logic [AW-1:0]    base_sp;
   logic             use_user;
   logic [IMG_W-1:0] ctx_img;
   logic [AW-1:0]    sel_sp;
   logic             sel_user;
   logic             last_step;
   logic [IMG_W-1:0] img_in;
   logic             unused_flg_mid;

   ctx_sp_select #(
      .AW(AW), .SWN_W(SWN_W), .USR_LO(USR_LO), .USR_HI(USR_HI)
   ) u_sel (
      .isp_i      (isp_i),
      .usp_i      (usp_i),
      .ustk_sel_i (ustk_sel_i),
      .swint_i    (swint_i),
      .swnum_i    (swnum_i),
      .sp_o       (sel_sp),
      .is_user_o  (sel_user)
   );

   // bytes from base-4 upward: PC low, PC mid, flag low, flag top nibble with PC top nibble
   assign img_in         = {flg_i[15:12], pc_i[19:16], flg_i[7:0], pc_i[15:0]};
   assign unused_flg_mid = ^flg_i[11:8];

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         step     <= 2'd0;
         base_sp  <= '0;
         use_user <= 1'b0;
         ctx_img  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               state    <= ST_WRITE;
               step     <= 2'd0;
               base_sp  <= sel_sp;
               use_user <= sel_user;
               ctx_img  <= img_in;
            end
            ST_WRITE: if (wr_ack_i) begin
               if (last_step) state <= ST_FIN;
               else           step  <= step + 2'd1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   ctx_write_plan #(
      .AW(AW), .CTX_B(CTX_BYTES), .DW(BUS_W)
   ) u_plan (
      .step_i (step),
      .odd_i  (base_sp[0]),
      .base_i (base_sp),
      .img_i  (ctx_img),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o),
      .word_o (wr_word_o),
      .last_o (last_step)
   );

   assign wr_en_o   = (state == ST_WRITE);
   assign done_o    = (state == ST_FIN);
   assign sp_o      = base_sp - AW'(CTX_BYTES);
   assign sp_user_o = use_user;

   // distance of the current write below the captured pointer
   logic [AW-1:0] back_off;
   assign back_off = base_sp - wr_addr_o;

   p_size_follows_parity_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |-> (wr_word_o == !base_sp[0]));

   p_word_even_addr_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && wr_word_o) |-> !wr_addr_o[0]);

   p_write_window_r5: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |-> (back_off >= AW'(1) && back_off <= AW'(CTX_BYTES)));

   p_descending_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && wr_ack_i && !last_step) |=> (wr_en_o && back_off > $past(back_off)));

   p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && !wr_ack_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)
                                  && $stable(wr_word_o)));

   p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE && start_i) |=> $stable(base_sp));

   p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (!done_o && !wr_en_o));
endmodule

// File: tb/ctx_save_seq_tb.sv
`timescale 1ns/1ps
module ctx_save_seq_tb;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic          start_i;
   logic [AW-1:0] isp_i, usp_i;
   logic          ustk_sel_i, swint_i;
   logic [5:0]    swnum_i;
   logic [15:0]   flg_i;
   logic [19:0]   pc_i;
   logic          wr_en_o, wr_word_o, wr_ack_i, done_o, sp_user_o;
   logic [AW-1:0] wr_addr_o, sp_o;
   logic [15:0]   wr_data_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   ctx_save_seq #(.AW(AW)) u_dut (
      .clk(clk), .rst(rst), .start_i(start_i), .isp_i(isp_i), .usp_i(usp_i),
      .ustk_sel_i(ustk_sel_i), .swint_i(swint_i), .swnum_i(swnum_i),
      .flg_i(flg_i), .pc_i(pc_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_word_o(wr_word_o), .wr_ack_i(wr_ack_i),
      .done_o(done_o), .sp_o(sp_o), .sp_user_o(sp_user_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic t_reset();
      rst = 1'b1; start_i = 1'b1; wr_ack_i = 1'b0;
      isp_i = 16'h1000; usp_i = 16'h2000; ustk_sel_i = 1'b0; swint_i = 1'b0;
      swnum_i = '0; flg_i = '0; pc_i = '0;
      repeat (3) @(negedge clk);
      chk(wr_en_o == 1'b0, "R1 strobe in reset", 32'(wr_en_o), 0);
      chk(done_o == 1'b0, "R1 done in reset", 32'(done_o), 0);
      start_i = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk(wr_en_o == 1'b0, "R1 strobe after reset", 32'(wr_en_o), 0);
      chk(done_o == 1'b0, "R1 done after reset", 32'(done_o), 0);
   endtask

   // one save; dly = idle cycles before each ack; poke = second start mid-save
   task automatic run_save(input logic [AW-1:0] isp, input logic [AW-1:0] usp,
                           input bit usel, input bit sw, input logic [5:0] num,
                           input logic [15:0] flg, input logic [19:0] pc,
                           input int dly, input bit poke);
      logic [AW-1:0] sel;
      bit            user;
      logic [7:0]    b [4];
      logic [AW-1:0] ea [4];
      logic [15:0]   ed [4];
      bit            ew [4];
      int            n;
      user = sw && (num >= 6'd32) && usel;
      sel  = user ? usp : isp;
      b[0] = pc[7:0];
      b[1] = pc[15:8];
      b[2] = flg[7:0];
      b[3] = {flg[15:12], pc[19:16]};
      if (!sel[0]) begin
         n = 2;
         ea[0] = sel - 16'd2; ed[0] = {b[3], b[2]}; ew[0] = 1'b1;
         ea[1] = sel - 16'd4; ed[1] = {b[1], b[0]}; ew[1] = 1'b1;
      end else begin
         n = 4;
         for (int k = 0; k < 4; k++) begin
            ea[k] = sel - AW'(k + 1);
            ed[k] = {8'h00, b[3-k]};
            ew[k] = 1'b0;
         end
      end
      @(negedge clk);
      isp_i = isp; usp_i = usp; ustk_sel_i = usel; swint_i = sw; swnum_i = num;
      flg_i = flg; pc_i = pc; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         chk(wr_en_o == 1'b1, "R7 strobe present", 32'(wr_en_o), 1);
         chk(wr_addr_o == ea[i], sel[0] ? "R4 address" : "R3 address",
             32'(wr_addr_o), 32'(ea[i]));
         chk(wr_word_o == ew[i], sel[0] ? "R4 size" : "R3 size",
             32'(wr_word_o), 32'(ew[i]));
         chk(wr_data_o == ed[i], sel[0] ? "R5 byte data" : "R5 R6 word data",
             32'(wr_data_o), 32'(ed[i]));
         for (int d = 0; d < dly; d++) begin
            if (poke && i == 0 && d == 0) begin
               start_i = 1'b1; isp_i = ~isp; usp_i = ~usp; flg_i = ~flg; pc_i = ~pc;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(wr_en_o && wr_addr_o == ea[i] && wr_data_o == ed[i],
                poke ? "R8 write held despite start" : "R7 write held before ack",
                32'(wr_addr_o), 32'(ea[i]));
         end
         wr_ack_i = 1'b1;
         @(negedge clk);
         wr_ack_i = 1'b0;
      end
      chk(done_o == 1'b1, "R9 done after last ack", 32'(done_o), 1);
      chk(sp_o == sel - 16'd4, poke ? "R8 pointer unchanged" : "R9 updated pointer",
          32'(sp_o), 32'(sel - 16'd4));
      chk(sp_user_o == user, "R2 pointer select", 32'(sp_user_o), 32'(user));
      @(negedge clk);
      chk(done_o == 1'b0, "R9 done single cycle", 32'(done_o), 0);
      chk(wr_en_o == 1'b0, "R9 quiet after done", 32'(wr_en_o), 0);
      if (poke) begin
         repeat (3) begin
            @(negedge clk);
            chk(wr_en_o == 1'b0, "R8 no extra writes", 32'(wr_en_o), 0);
         end
      end
   endtask

   task automatic t_hw_even();
      run_save(16'h0400, 16'h0801, 1'b1, 1'b0, 6'd40, 16'hA5C3, 20'h9_1234, 0, 1'b0);
   endtask

   task automatic t_user_odd_slow();
      run_save(16'h0400, 16'h0803, 1'b1, 1'b1, 6'd40, 16'h7E21, 20'hB_CDEF, 2, 1'b0);
   endtask

   task automatic t_sw_low_number();
      run_save(16'h0311, 16'h0900, 1'b1, 1'b1, 6'd31, 16'hF00F, 20'h1_0203, 1, 1'b0);
   endtask

   task automatic t_sw_bounds();
      run_save(16'h0300, 16'h0902, 1'b1, 1'b1, 6'd32, 16'h1234, 20'h5_6789, 0, 1'b0);
      run_save(16'h0300, 16'h0902, 1'b0, 1'b1, 6'd63, 16'h1234, 20'h5_6789, 0, 1'b0);
      run_save(16'h0700, 16'h0905, 1'b1, 1'b1, 6'd63, 16'hC0DE, 20'hF_FEDC, 0, 1'b0);
   endtask

   task automatic t_start_while_busy();
      run_save(16'h0501, 16'h0A00, 1'b0, 1'b0, 6'd0, 16'h8421, 20'h3_3C5A, 2, 1'b1);
      run_save(16'h0600, 16'h0A00, 1'b0, 1'b0, 6'd0, 16'h4812, 20'h6_0F0F, 2, 1'b1);
   endtask

   task automatic t_wrap();
      run_save(16'h0002, 16'h0000, 1'b0, 1'b0, 6'd0, 16'hBEEF, 20'h7_ABCD, 0, 1'b0);
      run_save(16'h0001, 16'h0000, 1'b0, 1'b0, 6'd0, 16'hCAFE, 20'h2_1357, 1, 1'b0);
   endtask

   initial begin
      #(200000.0 * 5.0);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
   end

   initial begin
      t_reset();
      t_hw_even();
      t_user_odd_slow();
      t_sw_low_number();
      t_sw_bounds();
      t_start_while_busy();
      t_wrap();
      report();
      $finish;
   end
endmodule